// File: doc/BRIEF.md
# Paged Memory Mapper

This block sits between a CPU with a 16-bit address bus and a physical memory larger than 64KB. The CPU address space is split into four fixed 16KB slots chosen by the two highest address bits. Each slot owns an 8-bit page register that names one 16KB page of physical memory. The 22-bit physical address is built from that page number and the 14 low CPU address bits, which are not changed. Up to 256 pages, or 4MB, can be reached.

Software changes the mapping by writing to the I/O ports. Four consecutive port numbers, starting at an aligned base, address the page registers of slots 0 to 3 in that order. Reading one of those ports returns the current page number for its slot. The CPU sees no difference between mapped and unmapped accesses, because translation is combinational.

Top module: `page_mapper`

## Requirements
- R1: After reset, the page register of slot n holds 3-n: slot 0 holds page 3, slot 1 page 2, slot 2 page 1 and slot 3 page 0.
- R2: Physical address bits [13:0] always equal CPU address bits [13:0].
- R3: Physical address bits [21:14] equal, in the same cycle, the page register of the slot selected by CPU address bits [15:14].
- R4: A write with `io_wr` high to port 0xFC+k (k = 0..3) loads `io_wdata` into the page register of slot k at the next rising clock edge. The new value is visible on `phys_addr` and `io_rdata` from that edge onward.
- R5: A write to any port outside 0xFC..0xFF changes no page register.
- R6: A write to slot k leaves the page registers of the other three slots unchanged.
- R7: When `io_port` is in 0xFC..0xFF, `io_hit` is 1 and `io_rdata` shows the page register of slot `io_port`-0xFC. For any other port, `io_hit` is 0 and `io_rdata` is 0.
- R8: While `io_wr` is low, no page register changes, whatever the values on `io_port` and `io_wdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU logical address |
| io_wr | input | 1 | I/O port write strobe |
| io_port | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data (page number) |
| phys_addr | output | 22 | Translated physical address |
| io_rdata | output | 8 | Page register readback for the addressed port |
| io_hit | output | 1 | Port number falls in the mapper's range |

## Verification
The assertions check on every cycle the following properties:
- The low 14 bits pass through unchanged.
- A write that hits a slot appears in the page field of the physical address one cycle later.
- When no write hit occurred in the previous cycle, a steady readback port shows a steady value.
- Ports outside the range read as zero.

Only the bench scenarios show the following:
- The reset mapping.
- That a write leaves the other slots unchanged, checked against a model of all four registers.
- That writes to ports outside the range, or with the strobe low, change nothing.
- The full translation over random addresses after long random write sequences.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
   // Reset page for a slot: slots count down so that the last slot starts on page 0
   function automatic int unsigned reset_page(input int unsigned slot, input int unsigned nslot);
      return nslot - 1 - slot;
   endfunction
endpackage

// File: rtl/mapper_port_decode.sv
module mapper_port_decode #(
   parameter int PORT_W    = 8,
   parameter int SLOT_BITS = 2,
   parameter logic [PORT_W-1:0] PORT_BASE = 8'hFC
) (
   input  logic [PORT_W-1:0]    port,
   output logic                 hit,
   output logic [SLOT_BITS-1:0] idx
);
   assign hit = (port[PORT_W-1:SLOT_BITS] == PORT_BASE[PORT_W-1:SLOT_BITS]);
   assign idx = port[SLOT_BITS-1:0];
endmodule

// File: rtl/mapper_page_regs.sv
module mapper_page_regs
   import mapper_pkg::*;
#(
   parameter int SLOT_BITS = 2,
   parameter int PAGE_W    = 8,
   localparam int NSLOT    = 1 << SLOT_BITS
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [SLOT_BITS-1:0]   wr_idx,
   input  logic [PAGE_W-1:0]      wr_page,
   output logic [NSLOT-1:0][PAGE_W-1:0] pages
);
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam logic [PAGE_W-1:0] RST_PAGE = PAGE_W'(reset_page(s, NSLOT));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pages[s] <= RST_PAGE;
         else if (wr_en && (wr_idx == SLOT_BITS'(s)))
            pages[s] <= wr_page;
      end
   end
endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate #(
   parameter int CPU_AW    = 16,
   parameter int SLOT_BITS = 2,
   parameter int PAGE_W    = 8,
   localparam int NSLOT    = 1 << SLOT_BITS,
   localparam int OFF_W    = CPU_AW - SLOT_BITS,
   localparam int PHYS_W   = PAGE_W + OFF_W
) (
   input  logic [CPU_AW-1:0]            cpu_addr,
   input  logic [NSLOT-1:0][PAGE_W-1:0] pages,
   output logic [PHYS_W-1:0]            phys_addr
);
   logic [SLOT_BITS-1:0] slot;
   logic [OFF_W-1:0]     offset;

   assign slot      = cpu_addr[CPU_AW-1 -: SLOT_BITS];
   assign offset    = cpu_addr[OFF_W-1:0];
   assign phys_addr = {pages[slot], offset};
endmodule

// File: rtl/page_mapper.sv
module page_mapper #(
   parameter int CPU_AW    = 16,
   parameter int SLOT_BITS = 2,
   parameter int PAGE_W    = 8,
   parameter int PORT_W    = 8,
   parameter logic [PORT_W-1:0] PORT_BASE = 8'hFC,
   localparam int NSLOT    = 1 << SLOT_BITS,
   localparam int PHYS_W   = PAGE_W + CPU_AW - SLOT_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic              io_wr,
   input  logic [PORT_W-1:0] io_port,
   input  logic [PAGE_W-1:0] io_wdata,
   output logic [PHYS_W-1:0] phys_addr,
   output logic [PAGE_W-1:0] io_rdata,
   output logic              io_hit
);
   if (SLOT_BITS < 1 || SLOT_BITS >= CPU_AW) begin : g_bad_slots
      $error("page_mapper: SLOT_BITS out of range");
   end
   if (PORT_W <= SLOT_BITS) begin : g_bad_port
      $error("page_mapper: port width too small");
   end
   if (PORT_BASE[SLOT_BITS-1:0] != '0) begin : g_bad_base
      $error("page_mapper: PORT_BASE must be aligned to the slot count");
   end
   if (PAGE_W < SLOT_BITS) begin : g_bad_page
      $error("page_mapper: PAGE_W cannot hold reset pages");
   end

   logic [SLOT_BITS-1:0]         idx;
   logic [NSLOT-1:0][PAGE_W-1:0] pages;

   mapper_port_decode #(.PORT_W(PORT_W), .SLOT_BITS(SLOT_BITS), .PORT_BASE(PORT_BASE)) u_dec (
      .port(io_port), .hit(io_hit), .idx(idx)
   );

   mapper_page_regs #(.SLOT_BITS(SLOT_BITS), .PAGE_W(PAGE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(io_wr && io_hit), .wr_idx(idx),
      .wr_page(io_wdata), .pages(pages)
   );

   mapper_xlate #(.CPU_AW(CPU_AW), .SLOT_BITS(SLOT_BITS), .PAGE_W(PAGE_W)) u_xl (
      .cpu_addr(cpu_addr), .pages(pages), .phys_addr(phys_addr)
   );

   assign io_rdata = io_hit ? pages[idx] : '0;
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
   parameter int CPU_AW    = 16,
   parameter int SLOT_BITS = 2,
   parameter int PAGE_W    = 8,
   parameter int PORT_W    = 8,
   localparam int OFF_W    = CPU_AW - SLOT_BITS,
   localparam int PHYS_W   = PAGE_W + OFF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CPU_AW-1:0] cpu_addr,
   input logic              io_wr,
   input logic [PORT_W-1:0] io_port,
   input logic [PAGE_W-1:0] io_wdata,
   input logic [PHYS_W-1:0] phys_addr,
   input logic [PAGE_W-1:0] io_rdata,
   input logic              io_hit
);
   logic wr_hit;
   assign wr_hit = io_wr && io_hit;

   assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

   assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_hit) && (cpu_addr[CPU_AW-1 -: SLOT_BITS] == $past(io_port[SLOT_BITS-1:0])))
      |-> (phys_addr[PHYS_W-1 -: PAGE_W] == $past(io_wdata)));

   assert_no_write_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_hit) && $stable(io_port) && io_hit) |-> $stable(io_rdata));

   assert_miss_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !io_hit |-> (io_rdata == '0));
endmodule

bind page_mapper mapper_checker #(
   .CPU_AW(CPU_AW), .SLOT_BITS(SLOT_BITS), .PAGE_W(PAGE_W), .PORT_W(PORT_W)
) u_checker (.*);

// File: tb/tb_page_mapper.sv
module tb_page_mapper;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [15:0] cpu_addr = '0;
   logic        io_wr = 0;
   logic [7:0]  io_port = '0;
   logic [7:0]  io_wdata = '0;
   logic [21:0] phys_addr;
   logic [7:0]  io_rdata;
   logic        io_hit;

   int checks = 0;
   int fails = 0;
   bit done = 0;
   logic [7:0] model [4];

   always #2 clk = ~clk;

   page_mapper dut (.*);

   function automatic logic [21:0] exp_phys(input logic [15:0] a);
      return {model[a[15:14]], a[13:0]};
   endfunction

   function automatic bit in_range(input logic [7:0] p);
      return p >= 8'hFC;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_xlate(input logic [15:0] a, input string req);
      @(negedge clk);
      cpu_addr = a;
      #0.5;
      chk(req, 32'(phys_addr), 32'(exp_phys(a)));
   endtask

   task automatic check_read(input logic [7:0] p, input string req);
      @(negedge clk);
      io_port = p;
      #0.5;
      chk(req, {23'd0, io_hit, io_rdata}, in_range(p) ? {23'd0, 1'b1, model[p[1:0]]} : 32'd0);
   endtask

   task automatic do_write(input bit wr, input logic [7:0] p, input logic [7:0] d);
      @(negedge clk);
      io_wr = wr; io_port = p; io_wdata = d;
      @(negedge clk);
      io_wr = 0;
      if (wr && in_range(p)) model[p[1:0]] = d;
   endtask

   task automatic check_all_slots(input string req);
      for (int k = 0; k < 4; k++) check_read(8'hFC + 8'(k), req);
   endtask

   initial begin
      for (int i = 0; i < 200000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int k = 0; k < 4; k++) model[k] = 8'(3 - k);
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state, R7 readback
      check_all_slots("R1");
      check_xlate(16'h0000, "R1");
      check_xlate(16'hFFFF, "R1");
      check_read(8'hFB, "R7");
      check_read(8'h00, "R7");

      // R2/R3 corner offsets
      check_xlate(16'h3FFF, "R2");
      check_xlate(16'h4000, "R3");
      check_xlate(16'hBFFF, "R3");

      // R4 direct writes, R6 others untouched
      do_write(1, 8'hFD, 8'hA5);
      check_xlate(16'h4123, "R4");
      check_all_slots("R6");
      do_write(1, 8'hFF, 8'hFF);
      check_xlate(16'hC000, "R4");
      do_write(1, 8'hFC, 8'h00);
      check_xlate(16'h2AAA, "R4");
      check_all_slots("R6");

      // R5 out-of-range writes
      do_write(1, 8'hFB, 8'h55);
      check_all_slots("R5");
      do_write(1, 8'h7C, 8'h66);
      check_all_slots("R5");

      // R8 strobe low
      do_write(0, 8'hFE, 8'h99);
      check_all_slots("R8");

      // random mix
      for (int it = 0; it < 400; it++) begin
         logic [7:0] p;
         p = ($urandom % 3 != 0) ? 8'hFC + 8'($urandom % 4) : 8'($urandom);
         do_write(($urandom % 5) != 0, p, 8'($urandom));
         check_xlate(16'($urandom), "R3");
         check_read(8'($urandom % 2 ? 8'hFC + 8'($urandom % 4) : $urandom), "R7");
      end
      check_all_slots("R6");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule